// File: doc/BRIEF.md
# Reloading Countdown Timer Channel

This block is one countdown timer channel with a counter of parameterised width, 16 or 32 bits. Software sets it up through four word-wide registers on a simple synchronous bus port. Once running, the counter drops by one on each clock cycle in which the selected tick-enable input is high. A control bit chooses between a fast tick input and a slow tick input. Both tick inputs are made outside the block.

When the counter steps below zero it either reloads the programmed start value (periodic mode) or wraps to its all-ones maximum (free-running mode). In both modes it raises a level interrupt. The interrupt stays high until software writes anything to the clear register. To reprogram the channel, software writes the control register with the run bit low, then writes the start value, then writes the control register with the run bit high.

The bus port is plain register access with no back-pressure. A write commits on the clock edge at which `bus_en` and `bus_we` are both high. Read data is combinational from `bus_addr` while `bus_en` is high and `bus_we` is low, and reads zero otherwise. The tick inputs are single-cycle enables, not clocks.

Top module: `cdt_channel`

## Requirements
- R1: After reset the start value, the count and the control word all read zero, and `irq` is low.
- R2: Word index 0 holds the start value, 1 the live count, 2 the control word and 3 the clear register. The control word reads back only bit 7 (run), bit 6 (periodic) and bit 3 (fast select), with every other bit zero. The clear register reads zero. Bits at and above CNT_W read zero in the start-value and count words.
- R3: A write to the start value also loads the counter, so a read in the next cycle returns the new value.
- R4: With run set, the count drops by exactly one per cycle in which the selected tick is high. With run clear, ticks leave the count unchanged.
- R5: With fast select set, only `tick_fast` advances the counter. With it clear, only `tick_slow` advances it.
- R6: In periodic mode, a tick that arrives while the count is zero reloads the start value.
- R7: In free-running mode, a tick that arrives while the count is zero wraps the count to all ones (2^CNT_W - 1).
- R8: Every underflow sets `irq`. `irq` then stays high until it is cleared, including while the channel is stopped.
- R9: A write of any data to the clear register drops `irq` on the next cycle. If an underflow happens in the same cycle as the clear, `irq` stays high.
- R10: Writes to the count word are ignored.
- R11: A start-value write in the same cycle as a tick takes precedence. The count takes the written value, and no underflow is signalled for that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| tick_fast | input | 1 | Fast tick enable |
| tick_slow | input | 1 | Slow tick enable |
| irq | output | 1 | Level interrupt, held until cleared |

## Verification
The count is visible on the bus one cycle after each tick or start-value write. A wrong decrement, a wrong tick source or a failed reload therefore shows up at the very next read of the count word. A corrupted control or start-value register shows up at the next underflow, as a wrong reload value or a wrong wrap target. An interrupt flag in the wrong state shows on `irq` within one cycle of the underflow or clear that should have moved it. It also shows on a later read taken while the channel is stopped.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  localparam int unsigned BUS_W = 32;

  // Control bit positions; software depends on these.
  localparam int unsigned CTRL_RUN_BIT  = 7;
  localparam int unsigned CTRL_PER_BIT  = 6;
  localparam int unsigned CTRL_FAST_BIT = 3;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_VALUE = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic run;
    logic periodic;
    logic fast;
  } ctrl_t;
endpackage

// File: rtl/cdt_regs.sv
`timescale 1ns/1ps
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0] count,
  output logic [BUS_W-1:0] bus_rdata,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] load_val,
  output logic             load_wr,
  output logic             clr_wr
);
  reg_sel_e         sel;
  logic             wr_stb;
  logic             rd_stb;
  logic             ctrl_wr;
  logic [BUS_W-1:0] load_ext;
  logic [BUS_W-1:0] count_ext;
  logic [BUS_W-1:0] ctrl_word;
  logic             unused_wbits;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_stb   = bus_en & bus_we;
  assign rd_stb   = bus_en & ~bus_we;
  assign load_wr  = wr_stb && (sel == REG_LOAD);
  assign ctrl_wr  = wr_stb && (sel == REG_CTRL);
  assign clr_wr   = wr_stb && (sel == REG_CLEAR);
  assign load_val = bus_wdata[CNT_W-1:0];
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      load_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl.run      <= bus_wdata[CTRL_RUN_BIT];
        ctrl.periodic <= bus_wdata[CTRL_PER_BIT];
        ctrl.fast     <= bus_wdata[CTRL_FAST_BIT];
      end
      if (load_wr) load_q <= load_val;
    end
  end

  // Zero extension of narrow channels onto the bus word.
  generate
    if (CNT_W < BUS_W) begin : g_narrow
      assign load_ext  = {{(BUS_W-CNT_W){1'b0}}, load_q};
      assign count_ext = {{(BUS_W-CNT_W){1'b0}}, count};

      AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (sel == REG_LOAD || sel == REG_VALUE)) |-> (bus_rdata[BUS_W-1:CNT_W] == '0)); // R2
    end else begin : g_full
      assign load_ext  = load_q;
      assign count_ext = count;
    end
  endgenerate

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_RUN_BIT]  = ctrl.run;
    ctrl_word[CTRL_PER_BIT]  = ctrl.periodic;
    ctrl_word[CTRL_FAST_BIT] = ctrl.fast;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_stb) begin
      unique case (sel)
        REG_LOAD:  bus_rdata = load_ext;
        REG_VALUE: bus_rdata = count_ext;
        REG_CTRL:  bus_rdata = ctrl_word;
        REG_CLEAR: bus_rdata = '0;
        default:   bus_rdata = '0;
      endcase
    end
  end

  AST_CTRL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && sel == REG_CTRL) |-> ((bus_rdata & ~32'h0000_00C8) == '0)); // R2
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && sel == REG_CLEAR) |-> (bus_rdata == '0)); // R2
  AST_LOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_wr |=> $stable(load_q)); // R6
endmodule

// File: rtl/cdt_counter.sv
`timescale 1ns/1ps
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic tick_sel;
  logic step;
  logic at_zero;

  assign tick_sel  = ctrl.fast ? tick_fast : tick_slow;
  assign step      = ctrl.run & tick_sel & ~load_wr;
  assign at_zero   = (count == '0);
  assign underflow = step & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load_wr) begin
      count <= load_val;
    end else if (step) begin
      if (at_zero) count <= ctrl.periodic ? load_q : CNT_MAX;
      else         count <= count - 1'b1;
    end
  end

  AST_LOAD_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (count == $past(load_val))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && tick_sel && !load_wr && count != '0) |=> (count == $past(count) - 1'b1)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !load_wr) |=> $stable(count)); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ctrl.periodic) |=> (count == $past(load_q))); // R6
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !ctrl.periodic) |=> (count == CNT_MAX)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |-> !underflow); // R11
endmodule

// File: rtl/cdt_irq.sv
`timescale 1ns/1ps
module cdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic underflow,
  input  logic clr_wr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (underflow) irq <= 1'b1;
    else if (clr_wr)    irq <= 1'b0;
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !underflow) |=> !irq); // R9
  AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !underflow) |=> !irq); // R8
endmodule

// File: rtl/cdt_channel.sv
`timescale 1ns/1ps
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_fast,
  input  logic        tick_slow,
  output logic        irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;
  logic             load_wr;
  logic             clr_wr;
  logic             underflow;

  cdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (count),
    .bus_rdata (bus_rdata),
    .ctrl      (ctrl),
    .load_q    (load_q),
    .load_val  (load_val),
    .load_wr   (load_wr),
    .clr_wr    (clr_wr)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .load_wr   (load_wr),
    .load_val  (load_val),
    .load_q    (load_q),
    .count     (count),
    .underflow (underflow)
  );

  cdt_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .underflow (underflow),
    .clr_wr    (clr_wr),
    .irq       (irq)
  );

  AST_VALUE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 2'd1 && !ctrl.run) |=> $stable(count)); // R10
endmodule

// File: tb/sim_cdt_channel.sv
`timescale 1ns/1ps
module sim_cdt_channel;
  localparam int W = 16;
  localparam logic [1:0] A_LOAD = 2'd0, A_VAL = 2'd1, A_CTRL = 2'd2, A_CLR = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  cdt_channel #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_vec = 0;
  int   n_bad = 0;
  logic mon_req = 1'b0;
  bit   done = 0;

  // Monitor: compares each observation against the head of the scoreboard.
  always @(negedge clk) begin
    if (mon_req) begin
      exp_t        e;
      logic [31:0] act;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty actual=%h expected=entry", bus_rdata);
      end else begin
        e   = sb.pop_front();
        act = e.is_irq ? {31'b0, irq} : bus_rdata;
        n_vec++;
        if (act !== e.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", e.tag, act, e.exp);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0; tick_fast = 0; tick_slow = 0; mon_req = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d,
                    input logic tf = 1'b0, input logic ts = 1'b0);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick_fast = tf; tick_slow = ts;
    cyc();
  endtask

  task automatic pulse(input logic tf, input logic ts, input int n);
    for (int i = 0; i < n; i++) begin
      tick_fast = tf; tick_slow = ts;
      cyc();
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    sb.push_back('{1'b0, exp, tag});
    bus_en = 1; bus_we = 0; bus_addr = a; mon_req = 1;
    cyc();
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    sb.push_back('{1'b1, {31'b0, exp}, tag});
    mon_req = 1;
    cyc();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    rd(A_LOAD, 32'h0, "R1 start value after reset");
    rd(A_VAL,  32'h0, "R1 count after reset");
    rd(A_CTRL, 32'h0, "R1 control after reset");
    chk_irq(1'b0, "R1 irq after reset");
    // R2 / R3: map, width extension, immediate load
    wr(A_LOAD, 32'h1234_0005);
    rd(A_LOAD, 32'h0000_0005, "R2 start value upper bits zero");
    rd(A_VAL,  32'h0000_0005, "R3 counter loaded by start-value write");
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, 32'h0000_00C8, "R2 control keeps only bits 7,6,3");
    rd(A_CLR,  32'h0, "R2 clear register reads zero");
    wr(A_CTRL, 32'h0);
    // R10: count word is read-only
    wr(A_VAL, 32'h0000_0077);
    rd(A_VAL, 32'h0000_0005, "R10 count write ignored");
    // R4: stopped channel ignores ticks
    pulse(1'b1, 1'b1, 3);
    rd(A_VAL, 32'h0000_0005, "R4 no count while stopped");
    // R5: fast select
    wr(A_CTRL, 32'h0000_00C8);
    pulse(1'b0, 1'b1, 2);
    rd(A_VAL, 32'h0000_0005, "R5 slow tick ignored with fast select");
    pulse(1'b1, 1'b0, 2);
    rd(A_VAL, 32'h0000_0003, "R4 two fast ticks step down two");
    wr(A_CTRL, 32'h0000_00C0);
    pulse(1'b1, 1'b0, 2);
    rd(A_VAL, 32'h0000_0003, "R5 fast tick ignored with slow select");
    pulse(1'b0, 1'b1, 1);
    rd(A_VAL, 32'h0000_0002, "R5 slow tick counts");
    // R6 / R8: periodic reload and interrupt
    pulse(1'b0, 1'b1, 2);
    rd(A_VAL, 32'h0, "R4 reached zero");
    chk_irq(1'b0, "R8 no irq before underflow");
    pulse(1'b0, 1'b1, 1);
    rd(A_VAL, 32'h0000_0005, "R6 periodic reload");
    chk_irq(1'b1, "R8 irq on underflow");
    wr(A_CTRL, 32'h0);
    pulse(1'b0, 1'b0, 3);
    chk_irq(1'b1, "R8 irq held while stopped");
    wr(A_CLR, 32'hABCD_1234);
    chk_irq(1'b0, "R9 any-value clear");
    // R7: free-running wrap
    wr(A_LOAD, 32'h1);
    wr(A_CTRL, 32'h0000_0088);
    pulse(1'b1, 1'b0, 1);
    chk_irq(1'b0, "R8 no irq at 1->0");
    pulse(1'b1, 1'b0, 1);
    rd(A_VAL, 32'h0000_FFFF, "R7 wrap to all ones");
    chk_irq(1'b1, "R8 irq on wrap");
    pulse(1'b1, 1'b0, 1);
    rd(A_VAL, 32'h0000_FFFE, "R7 keeps counting after wrap");
    // R9: clear in the same cycle as an underflow
    wr(A_CLR, 32'h0);
    chk_irq(1'b0, "R9 clear before collision test");
    wr(A_LOAD, 32'h0);
    wr(A_CLR, 32'h1, 1'b1, 1'b0);
    chk_irq(1'b1, "R9 underflow beats clear");
    rd(A_VAL, 32'h0000_FFFF, "R7 wrap during collision");
    // R11: start-value write beats a tick
    wr(A_CLR, 32'h5);
    wr(A_LOAD, 32'h0);
    wr(A_LOAD, 32'h0, 1'b1, 1'b0);
    chk_irq(1'b0, "R11 no underflow when write meets tick");
    rd(A_VAL, 32'h0, "R11 written zero kept");
    wr(A_LOAD, 32'h40, 1'b1, 1'b0);
    rd(A_VAL, 32'h0000_0040, "R11 written value wins over tick");
    cyc();
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule